// File: doc/BRIEF.md
# ROM/RAM Socket Address Decoder

This block maps a 20-bit byte address onto four memory sockets stacked at the very top of a 1 MB address space. Each socket owns a small internal byte array that behaves as ROM or as RAM, depending on how it was configured. A configuration port chooses the socket size, by programming the highest socket, and the device type of each lower socket. A separate mode input picks an 8-bit or a 16-bit bus arrangement. A load port fills any socket's array during initialisation. The bus side accepts one byte read or one byte write per cycle.

The highest socket (socket 3) decides the layout. Its size S (8 KB, 16 KB or 32 KB) becomes the size of every socket, and the window starts at 0x100000 - 4*S. In 8-bit mode the sockets follow each other upward from that base. In 16-bit mode they work as byte-lane pairs: sockets 0/1 form the lower pair and sockets 2/3 the upper pair. The even-numbered socket of a pair carries the even (low) byte and the odd-numbered socket the odd (high) byte.

Each socket keeps 2^STORE_LOG2 bytes of real storage (256 by default). Offsets beyond that wrap onto the same bytes, so the full decode can be exercised without a full-size array.

Top module: `memsock_top`

## Requirements
- R1: While reset is low and on the first cycle after it, every socket is unconfigured, the bus is in 8-bit mode, config_error and rd_valid are 0 and rd_data is 0xFF, so a read anywhere returns 0xFF.
- R2: cfg_code encodes 0 = empty, 1 = ROM 8 KB, 2 = ROM 16 KB, 3 = ROM 32 KB, 4 = RAM 8 KB, 5 = RAM 32 KB. Codes 1-3 on socket 3 set the size S. In 8-bit mode socket i then covers 0x100000 - 4*S + i*S up to S-1 bytes above that start, inclusive at both ends.
- R3: Socket 3 holds only ROM. A RAM code (4 or 5) sent to socket 3 pulses config_error and leaves that socket and the size unchanged.
- R4: Every accepted request on socket 3 (codes 0-3) leaves sockets 0, 1 and 2 empty. Code 0 also empties socket 3.
- R5: A lower socket takes a nonzero code only when socket 3 holds ROM and the code's size equals S. Otherwise the socket becomes empty and config_error pulses. No RAM code exists at 16 KB, so a 16 KB layout has no RAM. Code 0 empties a lower socket without error.
- R6: A bus write (bus_we = 1) that hits a RAM socket stores the byte. A bus write that hits a ROM socket, or no socket, changes nothing.
- R7: A read outside the 4*S window, or inside the range of an empty socket, returns 0xFF.
- R8: With mode_wide = 1, address bit 0 selects the lane (1 = odd socket, 0 = even socket of the pair). The pair index is the address bit just above bit log2(S) of the window offset. The byte index is (address - pair start) >> 1.
- R9: In 16-bit mode the upper pair is ROM only. A write aimed at socket 2 is ignored even when socket 2 is configured as RAM. The same write is stored in 8-bit mode.
- R10: A read request produces rd_valid = 1 and its data on the cycle after the request. Cycles without a read request give rd_valid = 0 on the next cycle.
- R11: The load port writes ld_data to byte ld_index of socket ld_site whatever that socket's type. When a load and a bus write target the same socket in one cycle, the load is stored and the bus write is dropped.
- R12: Each socket stores 2^STORE_LOG2 bytes. Byte index = offset mod 2^STORE_LOG2, so offsets that differ by a multiple of that depth share one byte.
- R13: config_error is high for exactly the one cycle after each rejected request. Codes 6 and 7 are rejected on any socket and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_site | input | 2 | Socket addressed by the request |
| cfg_code | input | 3 | Requested device code (see R2) |
| mode_we | input | 1 | Load a new bus mode |
| mode_wide | input | 1 | 1 = 16-bit paired mode, 0 = 8-bit mode |
| config_error | output | 1 | One-cycle pulse on a rejected request |
| ld_we | input | 1 | Initialisation load strobe |
| ld_site | input | 2 | Socket written by the load |
| ld_index | input | STORE_LOG2 | Byte index within the socket store |
| ld_data | input | 8 | Load byte |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Registered read byte |

## Verification
A configuration request is presented for one cycle. config_error is sampled half a cycle after the capturing edge and again one cycle later to confirm the pulse has ended. A read is presented for one cycle, and rd_valid and rd_data are sampled half a cycle after the next rising edge. Writes and loads take effect at their capturing edge, so the following read observes them. The bench computes every expected byte from an arithmetic model of the window base, socket spacing, lane split and index wrap, and sweeps every size and mode.

// File: rtl/memsock_pkg.sv
// memsock_pkg: shared constants, socket type enum and device-code helpers
// for the ROM/RAM socket decoder. Assumes exactly four sockets, a power of two.
package memsock_pkg;

    localparam int NUM_SOCK = 4;
    localparam int SEL_W    = $clog2(NUM_SOCK);
    localparam int TOP_SOCK = NUM_SOCK - 1;
    localparam int BYTE_W   = 8;
    localparam int CODE_W   = 3;
    localparam int SIZE_W   = 2;

    typedef enum logic [1:0] {
        SK_EMPTY = 2'd0,
        SK_ROM   = 2'd1,
        SK_RAM   = 2'd2
    } sock_kind_e;

    localparam logic [CODE_W-1:0] CODE_NONE   = 3'd0;
    localparam logic [CODE_W-1:0] CODE_ROM_X1 = 3'd1;
    localparam logic [CODE_W-1:0] CODE_ROM_X2 = 3'd2;
    localparam logic [CODE_W-1:0] CODE_ROM_X4 = 3'd3;
    localparam logic [CODE_W-1:0] CODE_RAM_X1 = 3'd4;
    localparam logic [CODE_W-1:0] CODE_RAM_X4 = 3'd5;

    // Size exponent above the unit size carried by a device code.
    function automatic logic [SIZE_W-1:0] code_size(input logic [CODE_W-1:0] c);
        case (c)
            CODE_ROM_X2:              return 2'd1;
            CODE_ROM_X4, CODE_RAM_X4: return 2'd2;
            default:                  return 2'd0;
        endcase
    endfunction

    // True when the code requests a writable device.
    function automatic logic code_is_ram(input logic [CODE_W-1:0] c);
        return (c == CODE_RAM_X1) || (c == CODE_RAM_X4);
    endfunction

endpackage

// File: rtl/memsock_cfg.sv
// memsock_cfg: holds the socket layout (size, per-socket type, bus mode) and
// judges configuration requests. The top socket sets the size and clears the
// lower ones; lower sockets must match that size. Rejections pulse cfg_err.
// Assumes at most one request per cycle; a request is applied at the edge.
module memsock_cfg
    import memsock_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_valid,
    input  logic [SEL_W-1:0]         cfg_site,
    input  logic [CODE_W-1:0]        cfg_code,
    input  logic                     mode_we,
    input  logic                     mode_wide,
    output sock_kind_e [NUM_SOCK-1:0] sock_state,
    output logic [SIZE_W-1:0]        size_code,
    output logic                     wide,
    output logic                     cfg_err
);

    sock_kind_e [NUM_SOCK-1:0] state_q, state_d;
    logic [SIZE_W-1:0]         size_q, size_d;
    logic                      wide_q;
    logic                      err_q, err_d;

    // Decide the next layout and whether the current request is rejected.
    always_comb begin
        state_d = state_q;
        size_d  = size_q;
        err_d   = 1'b0;
        if (cfg_valid) begin
            if (cfg_code > CODE_RAM_X4) begin
                err_d = 1'b1;
            end else if (cfg_site == SEL_W'(TOP_SOCK)) begin
                if (code_is_ram(cfg_code)) begin
                    err_d = 1'b1;
                end else begin
                    for (int i = 0; i < TOP_SOCK; i++) begin
                        state_d[i] = SK_EMPTY;
                    end
                    if (cfg_code == CODE_NONE) begin
                        state_d[TOP_SOCK] = SK_EMPTY;
                    end else begin
                        state_d[TOP_SOCK] = SK_ROM;
                        size_d            = code_size(cfg_code);
                    end
                end
            end else begin
                if (cfg_code == CODE_NONE) begin
                    state_d[cfg_site] = SK_EMPTY;
                end else if ((state_q[TOP_SOCK] == SK_ROM) &&
                             (code_size(cfg_code) == size_q)) begin
                    state_d[cfg_site] = code_is_ram(cfg_code) ? SK_RAM : SK_ROM;
                end else begin
                    state_d[cfg_site] = SK_EMPTY;
                    err_d             = 1'b1;
                end
            end
        end
    end

    // Register layout, bus mode and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= {NUM_SOCK{SK_EMPTY}};
            size_q  <= '0;
            wide_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            size_q  <= size_d;
            err_q   <= err_d;
            if (mode_we) begin
                wide_q <= mode_wide;
            end
        end
    end

    assign sock_state = state_q;
    assign size_code  = size_q;
    assign wide       = wide_q;
    assign cfg_err    = err_q;

endmodule

// File: rtl/memsock_decode.sv
// memsock_decode: combinational address decode. Finds the socket, the byte
// index into its store and whether the access may write. Assumes the socket
// window ends at the top of the address space and that STORE_LOG2 <= UNIT_LOG2.
module memsock_decode
    import memsock_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int UNIT_LOG2  = 13,
    parameter int STORE_LOG2 = 8
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [SIZE_W-1:0]         size_code,
    input  logic                      wide,
    input  sock_kind_e [NUM_SOCK-1:0] sock_state,
    output logic                      hit,
    output logic                      writable,
    output logic [SEL_W-1:0]          site,
    output logic [STORE_LOG2-1:0]     index
);

    localparam logic [SEL_W-1:0] LOCKED_EVEN = SEL_W'(NUM_SOCK - 2);

    int                  span;
    logic [ADDR_W-1:0]   region_mask;
    logic                in_region;
    logic [SEL_W-2:0]    pair_sel;

    // Window test: all address bits above the 4*S span must be ones.
    always_comb begin
        span        = UNIT_LOG2 + int'(size_code);
        region_mask = ~((ADDR_W'(1) << (span + SEL_W)) - ADDR_W'(1));
        in_region   = (addr & region_mask) == region_mask;
    end

    // Socket and byte index, straight or lane-paired.
    always_comb begin
        pair_sel = (SEL_W-1)'(addr >> (span + 1));
        if (wide) begin
            site  = {pair_sel, addr[0]};
            index = STORE_LOG2'(addr >> 1);
        end else begin
            site  = SEL_W'(addr >> span);
            index = STORE_LOG2'(addr);
        end
    end

    // Hit needs a configured socket; writes need RAM outside the locked lane.
    always_comb begin
        hit      = in_region && (sock_state[site] != SK_EMPTY);
        writable = hit && (sock_state[site] == SK_RAM) &&
                   !(wide && (site == LOCKED_EVEN));
    end

endmodule

// File: rtl/memsock_store.sv
// memsock_store: one socket's byte array, one write port, asynchronous read.
// The array itself carries no reset; contents come from loads and writes.
module memsock_store #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a byte when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/memsock_top.sv
// memsock_top: four ROM/RAM sockets at the top of the byte address space.
// Ties configuration, decode and storage together and registers read data.
// Assumes one bus access per cycle; loads take priority over bus writes.
module memsock_top
    import memsock_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int UNIT_LOG2  = 13,
    parameter int STORE_LOG2 = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_valid,
    input  logic [1:0]            cfg_site,
    input  logic [2:0]            cfg_code,
    input  logic                  mode_we,
    input  logic                  mode_wide,
    output logic                  config_error,
    input  logic                  ld_we,
    input  logic [1:0]            ld_site,
    input  logic [STORE_LOG2-1:0] ld_index,
    input  logic [7:0]            ld_data,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic                  rd_valid,
    output logic [7:0]            rd_data
);

    sock_kind_e [NUM_SOCK-1:0] sock_state;
    logic [SIZE_W-1:0]         size_code;
    logic                      wide_q;
    logic                      dec_hit;
    logic                      dec_writable;
    logic [SEL_W-1:0]          dec_site;
    logic [STORE_LOG2-1:0]     dec_index;
    logic [NUM_SOCK-1:0]       ld_hit;
    logic [NUM_SOCK-1:0]       bus_hit;
    logic [NUM_SOCK-1:0]       store_we;
    logic [STORE_LOG2-1:0]     wr_idx   [NUM_SOCK];
    logic [BYTE_W-1:0]         wr_dat   [NUM_SOCK];
    logic [BYTE_W-1:0]         sock_rd  [NUM_SOCK];
    logic                      rd_valid_q;
    logic [BYTE_W-1:0]         rd_data_q;

    memsock_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_site   (cfg_site),
        .cfg_code   (cfg_code),
        .mode_we    (mode_we),
        .mode_wide  (mode_wide),
        .sock_state (sock_state),
        .size_code  (size_code),
        .wide       (wide_q),
        .cfg_err    (config_error)
    );

    memsock_decode #(
        .ADDR_W     (ADDR_W),
        .UNIT_LOG2  (UNIT_LOG2),
        .STORE_LOG2 (STORE_LOG2)
    ) u_dec (
        .addr       (bus_addr),
        .size_code  (size_code),
        .wide       (wide_q),
        .sock_state (sock_state),
        .hit        (dec_hit),
        .writable   (dec_writable),
        .site       (dec_site),
        .index      (dec_index)
    );

    // Per-socket write steering and storage.
    for (genvar g = 0; g < NUM_SOCK; g++) begin : g_sock
        assign ld_hit[g]   = ld_we && (ld_site == SEL_W'(g));
        assign bus_hit[g]  = bus_req && bus_we && dec_writable &&
                             (dec_site == SEL_W'(g));
        assign store_we[g] = ld_hit[g] || bus_hit[g];
        assign wr_idx[g]   = ld_hit[g] ? ld_index : dec_index;
        assign wr_dat[g]   = ld_hit[g] ? ld_data  : bus_wdata;

        memsock_store #(
            .IDX_W  (STORE_LOG2),
            .DATA_W (BYTE_W)
        ) u_store (
            .clk     (clk),
            .we      (store_we[g]),
            .wr_idx  (wr_idx[g]),
            .wr_data (wr_dat[g]),
            .rd_idx  (dec_index),
            .rd_data (sock_rd[g])
        );
    end

    // Register the read result; a miss returns all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= 8'hFF;
        end else begin
            rd_valid_q <= bus_req && !bus_we;
            if (bus_req && !bus_we) begin
                rd_data_q <= dec_hit ? sock_rd[dec_site] : 8'hFF;
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

endmodule

// File: rtl/memsock_chk.sv
// memsock_chk: protocol and policy checks for memsock_top, bound below.
module memsock_chk
    import memsock_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_valid,
    input logic [1:0]                cfg_site,
    input logic [2:0]                cfg_code,
    input logic                      config_error,
    input logic                      ld_we,
    input logic                      bus_req,
    input logic                      bus_we,
    input logic                      rd_valid,
    input logic [7:0]                rd_data,
    input logic                      dec_hit,
    input logic [SEL_W-1:0]          dec_site,
    input logic                      wide_q,
    input sock_kind_e [NUM_SOCK-1:0] sock_state,
    input logic [NUM_SOCK-1:0]       store_we
);

    a_r10_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> rd_valid);

    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !rd_valid);

    a_r7_miss_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !dec_hit) |=> (rd_data == 8'hFF));

    a_r3_top_ram_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_site == SEL_W'(TOP_SOCK) && code_is_ram(cfg_code))
        |=> config_error);

    a_r3_top_never_ram: assert property (@(posedge clk) disable iff (!rst_n)
        sock_state[TOP_SOCK] != SK_RAM);

    a_r4_lowers_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_site == SEL_W'(TOP_SOCK) && cfg_code <= CODE_ROM_X4)
        |=> (sock_state[0] == SK_EMPTY && sock_state[1] == SK_EMPTY &&
             sock_state[2] == SK_EMPTY));

    a_r13_error_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> $past(cfg_valid));

    a_r6_rom_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !ld_we && dec_hit && sock_state[dec_site] != SK_RAM)
        |-> (store_we == '0));

    a_r9_upper_pair_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !ld_we && wide_q && dec_site == SEL_W'(NUM_SOCK - 2))
        |-> (store_we == '0));

endmodule

bind memsock_top memsock_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .cfg_site     (cfg_site),
    .cfg_code     (cfg_code),
    .config_error (config_error),
    .ld_we        (ld_we),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .dec_hit      (dec_hit),
    .dec_site     (dec_site),
    .wide_q       (wide_q),
    .sock_state   (sock_state),
    .store_we     (store_we)
);

// File: tb/memsock_tb.sv
// Self-checking bench: sweeps every size and bus mode against an arithmetic model.
module memsock_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int UNIT_LOG2  = 13;
    localparam int STORE_LOG2 = 8;
    localparam int DEPTH      = 1 << STORE_LOG2;
    localparam int WATCHDOG   = 190000;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  cfg_valid;
    logic [1:0]            cfg_site;
    logic [2:0]            cfg_code;
    logic                  mode_we;
    logic                  mode_wide;
    logic                  config_error;
    logic                  ld_we;
    logic [1:0]            ld_site;
    logic [STORE_LOG2-1:0] ld_index;
    logic [7:0]            ld_data;
    logic                  bus_req;
    logic                  bus_we;
    logic [19:0]           bus_addr;
    logic [7:0]            bus_wdata;
    logic                  rd_valid;
    logic [7:0]            rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model: 0 empty, 1 ROM, 2 RAM
    int         m_state [4];
    int         m_size;
    bit         m_wide;
    logic [7:0] m_mem [4][DEPTH];

    memsock_top #(
        .ADDR_W     (20),
        .UNIT_LOG2  (UNIT_LOG2),
        .STORE_LOG2 (STORE_LOG2)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_valid    (cfg_valid),
        .cfg_site     (cfg_site),
        .cfg_code     (cfg_code),
        .mode_we      (mode_we),
        .mode_wide    (mode_wide),
        .config_error (config_error),
        .ld_we        (ld_we),
        .ld_site      (ld_site),
        .ld_index     (ld_index),
        .ld_data      (ld_data),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int span_of(input int sz);
        return (1 << UNIT_LOG2) << sz;
    endfunction

    function automatic int win_base();
        return 'h100000 - 4 * span_of(m_size);
    endfunction

    // Socket hit by an address, or -1; idx gets the wrapped byte index.
    function automatic int m_lookup(input int a, output int idx);
        int s_len;
        int base;
        int rel;
        int s;
        s_len = span_of(m_size);
        base  = win_base();
        idx   = 0;
        if (a < base || a > 'hFFFFF) return -1;
        rel = a - base;
        if (!m_wide) begin
            s   = rel / s_len;
            idx = (rel % s_len) % DEPTH;
        end else begin
            s   = 2 * (rel / (2 * s_len)) + (a % 2);
            idx = ((rel % (2 * s_len)) / 2) % DEPTH;
        end
        if (m_state[s] == 0) return -1;
        return s;
    endfunction

    function automatic int code_sz(input int c);
        if (c == 2) return 1;
        if (c == 3 || c == 5) return 2;
        return 0;
    endfunction

    task automatic do_cfg(input int site, input int code, input string req);
        bit exp_err;
        exp_err = 1'b0;
        if (code > 5) begin
            exp_err = 1'b1;
        end else if (site == 3) begin
            if (code >= 4) begin
                exp_err = 1'b1;
            end else begin
                for (int i = 0; i < 3; i++) m_state[i] = 0;
                m_state[3] = (code == 0) ? 0 : 1;
                if (code != 0) m_size = code_sz(code);
            end
        end else begin
            if (code == 0) begin
                m_state[site] = 0;
            end else if (m_state[3] == 1 && code_sz(code) == m_size) begin
                m_state[site] = (code >= 4) ? 2 : 1;
            end else begin
                m_state[site] = 0;
                exp_err = 1'b1;
            end
        end
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_site  = 2'(site);
        cfg_code  = 3'(code);
        @(negedge clk);
        cfg_valid = 1'b0;
        check(req, "config_error", 32'(config_error), 32'(exp_err));
        @(negedge clk);
        check("R13", "config_error pulse end", 32'(config_error), 32'd0);
    endtask

    task automatic do_mode(input bit w);
        @(negedge clk);
        mode_we   = 1'b1;
        mode_wide = w;
        @(negedge clk);
        mode_we   = 1'b0;
        m_wide    = w;
    endtask

    task automatic do_load(input int site, input int idx, input logic [7:0] d);
        @(negedge clk);
        ld_we    = 1'b1;
        ld_site  = 2'(site);
        ld_index = STORE_LOG2'(idx);
        ld_data  = d;
        m_mem[site][idx] = d;
        @(negedge clk);
        ld_we    = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        int s;
        int idx;
        s = m_lookup(a, idx);
        if (s >= 0 && m_state[s] == 2 && !(m_wide && s == 2)) m_mem[s][idx] = d;
        @(negedge clk);
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = 20'(a);
        bus_wdata = d;
        @(negedge clk);
        bus_req   = 1'b0;
        bus_we    = 1'b0;
    endtask

    task automatic do_read(input int a, input string req);
        int s;
        int idx;
        logic [7:0] exp;
        s   = m_lookup(a, idx);
        exp = (s < 0) ? 8'hFF : m_mem[s][idx];
        @(negedge clk);
        bus_req  = 1'b1;
        bus_we   = 1'b0;
        bus_addr = 20'(a);
        @(negedge clk);
        bus_req  = 1'b0;
        check("R10", "rd_valid", 32'(rd_valid), 32'd1);
        check(req, $sformatf("rd_data @%05h", a), 32'(rd_data), 32'(exp));
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        int s_len;
        rst_n = 1'b0; cfg_valid = 1'b0; cfg_site = '0; cfg_code = '0;
        mode_we = 1'b0; mode_wide = 1'b0; ld_we = 1'b0; ld_site = '0;
        ld_index = '0; ld_data = '0; bus_req = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        for (int i = 0; i < 4; i++) m_state[i] = 0;
        m_size = 0;
        m_wide = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "config_error", 32'(config_error), 32'd0);
        check("R1", "rd_valid", 32'(rd_valid), 32'd0);
        check("R1", "rd_data", 32'(rd_data), 32'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rd_valid after reset", 32'(rd_valid), 32'd0);
        do_read('hF8000, "R1");
        do_read('hFE000, "R1");
        do_read('hFFFFF, "R1");

        // rejections from the empty state
        do_cfg(0, 1, "R5");
        do_cfg(3, 4, "R3");
        do_cfg(1, 6, "R13");

        // sweep every size and both bus modes
        for (int sz = 0; sz < 3; sz++) begin
            for (int w = 0; w < 2; w++) begin
                do_mode(w[0]);
                do_cfg(3, sz + 1, "R4");
                do_cfg(0, (sz == 2) ? 5 : 4, "R5");
                do_cfg(1, ((sz + 1) % 3) + 1, "R5");
                do_cfg(1, sz + 1, "R2");
                do_cfg(2, (sz == 2) ? 5 : 4, "R5");
                do_cfg(3, 5, "R3");
                do_cfg(2, 7, "R13");
                for (int s = 0; s < 4; s++) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        do_load(s, i, 8'(s * 37 + i * 3 + 5));
                    end
                end
                for (int a = 'hE0000; a <= 'hFFFFF; a += 61) do_write(a, 8'(a ^ (a >> 8)));
                for (int a = 'hE0000; a <= 'hFFFFF; a += 61) do_read(a, w ? "R8" : "R6");
                s_len = span_of(m_size);
                base  = win_base();
                do_read(base - 1, "R7");
                do_read(base, "R2");
                do_read(base + s_len - 1, "R2");
                do_read(base + s_len, "R2");
                do_read(base + 2 * s_len - 1, "R8");
                do_read('hFFFFF, "R2");
            end
        end

        // state now: 32 KB layout, 16-bit mode, socket 2 is RAM
        s_len = span_of(m_size);
        base  = win_base();
        // R9: even lane of the upper pair refuses writes in 16-bit mode
        do_load(2, 8, 8'h11);
        do_write(base + 2 * s_len + 16, 8'h77);
        do_read(base + 2 * s_len + 16, "R9");
        // same byte is writable in 8-bit mode
        do_mode(1'b0);
        do_write(base + 2 * s_len + 8, 8'h77);
        do_read(base + 2 * s_len + 8, "R9");
        // R12: index wraps at the store depth
        do_write(base + DEPTH + 5, 8'h5A);
        do_read(base + 5, "R12");
        // R11: load beats a bus write to the same socket in one cycle
        @(negedge clk);
        ld_we = 1'b1; ld_site = 2'd0; ld_index = STORE_LOG2'(9); ld_data = 8'hA5;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 20'(base + 16); bus_wdata = 8'h3C;
        m_mem[0][9] = 8'hA5;
        @(negedge clk);
        ld_we = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
        do_read(base + 9, "R11");
        do_read(base + 16, "R11");
        // R11: load into a ROM socket is visible
        do_load(1, 3, 8'hC3);
        do_read(base + s_len + 3, "R11");
        // R4: top reprogrammed, lower sockets read as empty
        do_cfg(3, 3, "R4");
        do_read(base, "R4");
        do_read(base + 2 * s_len, "R4");
        do_read('hFFFFF, "R4");
        // R4: code 0 on the top socket empties everything
        do_cfg(3, 0, "R4");
        do_read('hFFFFF, "R7");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule